// File: doc/BRIEF.md
# Microcoded Multicycle Processor Controller

This block is the control unit for a small 16-bit load/store processor. It holds a microinstruction store and a microsequencer. Every instruction passes through one shared fetch microinstruction and one shared decode microinstruction. The decode step dispatches on the opcode to a short routine of one to three cycles. The last microinstruction of that routine sends control back to fetch.

The datapath reads the outputs directly as its control lines. These lines cover:
- instruction register load
- PC increment
- ALU operand selects and ALU operation
- register-file write, write-data source and destination format
- instruction-or-data address select
- memory write
- PC load, conditional PC load and PC source

The block takes the opcode and function fields of the instruction register as inputs. Each microinstruction carries a sequencing code: advance (0), dispatch (1) or return (2). Each routine sits at a fixed microaddress. The shift-left routine is at 0x20 and the store routine is at 0x50.

Top module: `uctl_top`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become the fetch word: `ir_wr_o`=1, `pc_inc_o`=1, all other outputs 0. The first cycle after reset is therefore a fetch.
- R2: The cycle after every fetch is decode. It drives `alu_a_pc_o`=1, `alu_b_sel_o`=1 (sign-extended immediate) and `alu_op_o`=0 (add). All write and load outputs are 0.
- R3: The opcode is `op_i`, taken from IR[15:12] and sampled in decode. The opcode assignment is:
  - 0 nop, 1 R-format, 2 sll, 3 srl
  - 4 lw, 5 sw, 6 j, 7 beq
  - 8 addi, 9 subi, 10 andi, 11 ori
  - 12 to 15 are unassigned and run the nop routine.
  
  The nop routine is one cycle with all outputs 0, followed by fetch.
- R4: R-format spends two cycles. In the first, `alu_op_o` equals `func_i` (IR[3:0]) and `alu_b_sel_o`=0 (register B). In the second, `reg_wr_o`=1 with `reg_src_mem_o`=0 (ALU result). Fetch follows.
- R5: sll and srl each spend two cycles. In the first, ALU operand A is shifted, with `alu_op_o`=4 for left and 5 for right. In the second, `reg_wr_o`=1 and `reg_dst_fmt_o`=1 (destination from IR[10]). Fetch follows.
- R6: sw spends two cycles. In the first, `alu_b_sel_o`=1 and `alu_op_o`=0 (A plus sign-extended offset). In the second, `iord_o`=1 and `mem_wr_o`=1. Fetch follows.
- R7: lw spends three cycles, and fetch follows:
  - first: address add, as in sw;
  - second: `iord_o`=1 with `mem_wr_o`=0;
  - third: `reg_wr_o`=1 and `reg_src_mem_o`=1.
- R8: The immediate ALU instructions spend two cycles. Their first cycles are:
  - addi: `alu_b_sel_o`=1, op 0 (add);
  - subi: `alu_b_sel_o`=1, op 1 (sub);
  - andi: `alu_b_sel_o`=2 (zero-extended), op 2 (and);
  - ori: `alu_b_sel_o`=2, op 3 (or).
  
  In the second cycle, `reg_wr_o`=1 from the ALU. Fetch follows.
- R9: j and beq each spend one cycle. j asserts `pc_ld_o`=1 and `pc_src_jmp_o`=1. beq asserts `alu_op_o`=1 (A minus B) and `pc_ld_cond_o`=1, with `pc_src_jmp_o`=0 (target from the ALU result register). Fetch follows.
- R10: Any output not named for a cycle is 0. A cycle that asserts `reg_wr_o` or `mem_wr_o` is always followed by fetch. No instruction takes more than 5 cycles from fetch to the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Opcode field, IR[15:12] |
| func_i | input | 4 | Function field, IR[3:0] |
| ir_wr_o | output | 1 | Load instruction register |
| pc_inc_o | output | 1 | Increment PC |
| alu_a_pc_o | output | 1 | ALU A: 1 = PC, 0 = register A |
| alu_b_sel_o | output | 2 | ALU B: 0 reg B, 1 sign-ext imm, 2 zero-ext imm |
| alu_op_o | output | 4 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 sll, 5 srl |
| reg_wr_o | output | 1 | Register file write |
| reg_src_mem_o | output | 1 | Write data: 1 = memory data, 0 = ALU result |
| reg_dst_fmt_o | output | 1 | Destination taken from IR[10] |
| iord_o | output | 1 | Memory address: 1 = ALU result, 0 = PC |
| mem_wr_o | output | 1 | Memory write |
| pc_ld_o | output | 1 | Unconditional PC load |
| pc_ld_cond_o | output | 1 | PC load if ALU result is zero |
| pc_src_jmp_o | output | 1 | PC source: 1 = jump target, 0 = ALU result register |

## Verification
The assertions check several rules on every cycle:
- decode always follows fetch with the branch-target add;
- a write cycle is always followed by fetch;
- memory writes always use the data address;
- fetch never carries a write;
- the distance between fetches never exceeds five cycles.

Only the bench's scenarios show the exact per-opcode routine contents. These are the dispatch origins, operand selects and ALU codes of each instruction, the function-field pass-through for R-format, and the fallback of unassigned opcodes to nop. The bench also checks recovery from a reset that arrives mid-routine.

// File: rtl/uctl_pkg.sv
package uctl_pkg;
  localparam int UPC_W  = 7;
  localparam int UDEPTH = 1 << UPC_W;
  localparam int OP_W   = 4;
  localparam int ALU_W  = 4;

  typedef enum logic [1:0] {
    SQ_NEXT = 2'd0,
    SQ_DISP = 2'd1,
    SQ_RET  = 2'd2
  } seq_t;

  localparam logic [ALU_W-1:0] A_ADD = 4'd0;
  localparam logic [ALU_W-1:0] A_SUB = 4'd1;
  localparam logic [ALU_W-1:0] A_AND = 4'd2;
  localparam logic [ALU_W-1:0] A_OR  = 4'd3;
  localparam logic [ALU_W-1:0] A_SLL = 4'd4;
  localparam logic [ALU_W-1:0] A_SRL = 4'd5;

  localparam logic [1:0] B_REG = 2'd0;
  localparam logic [1:0] B_SX  = 2'd1;
  localparam logic [1:0] B_ZX  = 2'd2;

  localparam logic [UPC_W-1:0] U_FETCH = 7'h00;
  localparam logic [UPC_W-1:0] U_DEC   = 7'h01;
  localparam logic [UPC_W-1:0] U_NOP   = 7'h08;
  localparam logic [UPC_W-1:0] U_RF    = 7'h10;
  localparam logic [UPC_W-1:0] U_SLL   = 7'h20;
  localparam logic [UPC_W-1:0] U_SRL   = 7'h28;
  localparam logic [UPC_W-1:0] U_LW    = 7'h40;
  localparam logic [UPC_W-1:0] U_SW    = 7'h50;
  localparam logic [UPC_W-1:0] U_J     = 7'h58;
  localparam logic [UPC_W-1:0] U_BEQ   = 7'h60;
  localparam logic [UPC_W-1:0] U_ADDI  = 7'h68;
  localparam logic [UPC_W-1:0] U_SUBI  = 7'h70;
  localparam logic [UPC_W-1:0] U_ANDI  = 7'h78;
  localparam logic [UPC_W-1:0] U_ORI   = 7'h7C;

  typedef struct packed {
    seq_t             seq;
    logic             ir_wr;
    logic             pc_inc;
    logic             a_pc;
    logic [1:0]       b_sel;
    logic             use_func;
    logic [ALU_W-1:0] op;
    logic             reg_wr;
    logic             src_mem;
    logic             dst_fmt;
    logic             iord;
    logic             mem_wr;
    logic             pc_ld;
    logic             pc_ld_cond;
    logic             pc_jmp;
  } uword_t;

  localparam int UW_W = $bits(uword_t);

  function automatic uword_t uword_at(input logic [UPC_W-1:0] a);
    uword_t w;
    w     = '0;
    w.seq = SQ_RET;
    case (a)
      U_FETCH:      begin w.seq = SQ_NEXT; w.ir_wr = 1'b1; w.pc_inc = 1'b1; end
      U_DEC:        begin w.seq = SQ_DISP; w.a_pc = 1'b1; w.b_sel = B_SX; w.op = A_ADD; end
      U_NOP:        w.seq = SQ_RET;
      U_RF:         begin w.seq = SQ_NEXT; w.b_sel = B_REG; w.use_func = 1'b1; end
      U_RF + 7'd1:  w.reg_wr = 1'b1;
      U_SLL:        begin w.seq = SQ_NEXT; w.op = A_SLL; end
      U_SLL + 7'd1: begin w.reg_wr = 1'b1; w.dst_fmt = 1'b1; end
      U_SRL:        begin w.seq = SQ_NEXT; w.op = A_SRL; end
      U_SRL + 7'd1: begin w.reg_wr = 1'b1; w.dst_fmt = 1'b1; end
      U_LW:         begin w.seq = SQ_NEXT; w.b_sel = B_SX; w.op = A_ADD; end
      U_LW + 7'd1:  begin w.seq = SQ_NEXT; w.iord = 1'b1; end
      U_LW + 7'd2:  begin w.reg_wr = 1'b1; w.src_mem = 1'b1; end
      U_SW:         begin w.seq = SQ_NEXT; w.b_sel = B_SX; w.op = A_ADD; end
      U_SW + 7'd1:  begin w.iord = 1'b1; w.mem_wr = 1'b1; end
      U_J:          begin w.pc_ld = 1'b1; w.pc_jmp = 1'b1; end
      U_BEQ:        begin w.op = A_SUB; w.pc_ld_cond = 1'b1; end
      U_ADDI:       begin w.seq = SQ_NEXT; w.b_sel = B_SX; w.op = A_ADD; end
      U_ADDI + 7'd1: w.reg_wr = 1'b1;
      U_SUBI:       begin w.seq = SQ_NEXT; w.b_sel = B_SX; w.op = A_SUB; end
      U_SUBI + 7'd1: w.reg_wr = 1'b1;
      U_ANDI:       begin w.seq = SQ_NEXT; w.b_sel = B_ZX; w.op = A_AND; end
      U_ANDI + 7'd1: w.reg_wr = 1'b1;
      U_ORI:        begin w.seq = SQ_NEXT; w.b_sel = B_ZX; w.op = A_OR; end
      U_ORI + 7'd1: w.reg_wr = 1'b1;
      default:      w.seq = SQ_RET;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/uctl_rom.sv
module uctl_rom
  import uctl_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int DW = UW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] q_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(uword_at(UPC_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= mem[0];
    else     q_o <= mem[addr_i];
  end
endmodule

// File: rtl/uctl_dispatch.sv
module uctl_dispatch
  import uctl_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int AW = UPC_W
) (
  input  logic [OW-1:0] op_i,
  output logic [AW-1:0] origin_o
);
  always_comb begin
    case (op_i)
      4'd1:    origin_o = U_RF;
      4'd2:    origin_o = U_SLL;
      4'd3:    origin_o = U_SRL;
      4'd4:    origin_o = U_LW;
      4'd5:    origin_o = U_SW;
      4'd6:    origin_o = U_J;
      4'd7:    origin_o = U_BEQ;
      4'd8:    origin_o = U_ADDI;
      4'd9:    origin_o = U_SUBI;
      4'd10:   origin_o = U_ANDI;
      4'd11:   origin_o = U_ORI;
      default: origin_o = U_NOP;
    endcase
  end
endmodule

// File: rtl/uctl_seq.sv
module uctl_seq
  import uctl_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_t          seq_i,
  input  logic [AW-1:0] origin_i,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] upc_q;

  always_comb begin
    case (seq_i)
      SQ_NEXT: next_o = upc_q + AW'(1);
      SQ_DISP: next_o = origin_i;
      default: next_o = U_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc_q <= U_FETCH;
    else     upc_q <= next_o;
  end
endmodule

// File: rtl/uctl_top.sv
module uctl_top
  import uctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [3:0]       func_i,
  output logic             ir_wr_o,
  output logic             pc_inc_o,
  output logic             alu_a_pc_o,
  output logic [1:0]       alu_b_sel_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             reg_wr_o,
  output logic             reg_src_mem_o,
  output logic             reg_dst_fmt_o,
  output logic             iord_o,
  output logic             mem_wr_o,
  output logic             pc_ld_o,
  output logic             pc_ld_cond_o,
  output logic             pc_src_jmp_o
);
  logic [UPC_W-1:0] origin, next_addr;
  logic [UW_W-1:0]  q_raw;
  uword_t           uw;

  assign uw = uword_t'(q_raw);

  uctl_dispatch #(.OW(OP_W), .AW(UPC_W)) u_disp (
    .op_i(op_i), .origin_o(origin)
  );

  uctl_seq #(.AW(UPC_W)) u_seq (
    .clk(clk), .rst(rst), .seq_i(uw.seq), .origin_i(origin), .next_o(next_addr)
  );

  uctl_rom #(.AW(UPC_W), .DW(UW_W)) u_rom (
    .clk(clk), .rst(rst), .addr_i(next_addr), .q_o(q_raw)
  );

  assign ir_wr_o       = uw.ir_wr;
  assign pc_inc_o      = uw.pc_inc;
  assign alu_a_pc_o    = uw.a_pc;
  assign alu_b_sel_o   = uw.b_sel;
  assign alu_op_o      = uw.use_func ? func_i : uw.op;
  assign reg_wr_o      = uw.reg_wr;
  assign reg_src_mem_o = uw.src_mem;
  assign reg_dst_fmt_o = uw.dst_fmt;
  assign iord_o        = uw.iord;
  assign mem_wr_o      = uw.mem_wr;
  assign pc_ld_o       = uw.pc_ld;
  assign pc_ld_cond_o  = uw.pc_ld_cond;
  assign pc_src_jmp_o  = uw.pc_jmp;
endmodule

// File: rtl/uctl_chk.sv
module uctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ir_wr_o,
  input logic       pc_inc_o,
  input logic       alu_a_pc_o,
  input logic [1:0] alu_b_sel_o,
  input logic [3:0] alu_op_o,
  input logic       reg_wr_o,
  input logic       iord_o,
  input logic       mem_wr_o
);
  logic [2:0] since_fetch;
  logic       started;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_fetch <= 3'd0;
      started     <= 1'b0;
    end else begin
      started <= 1'b1;
      if (ir_wr_o) since_fetch <= 3'd1;
      else if (since_fetch != 3'd7) since_fetch <= since_fetch + 3'd1;
    end
  end

  // R1
  fetch_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (!started) |-> (ir_wr_o && pc_inc_o && !reg_wr_o && !mem_wr_o));

  // R2
  decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr_o |=> (alu_a_pc_o && alu_b_sel_o == 2'd1 && alu_op_o == 4'd0 && !ir_wr_o));

  // R10
  write_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_o || mem_wr_o) |=> ir_wr_o);

  // R6
  store_uses_data_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> iord_o);

  // R10
  fetch_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr_o |-> (!reg_wr_o && !mem_wr_o && !iord_o));

  // R10
  bounded_routine_chk: assert property (@(posedge clk) disable iff (rst)
    (!ir_wr_o && started) |-> (since_fetch <= 3'd4));
endmodule

bind uctl_top uctl_chk u_chk (
  .clk(clk), .rst(rst), .ir_wr_o(ir_wr_o), .pc_inc_o(pc_inc_o),
  .alu_a_pc_o(alu_a_pc_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
  .reg_wr_o(reg_wr_o), .iord_o(iord_o), .mem_wr_o(mem_wr_o)
);

// File: tb/sim_uctl_top.sv
module sim_uctl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [3:0] func_i = 4'd0;
  logic ir_wr_o, pc_inc_o, alu_a_pc_o, reg_wr_o, reg_src_mem_o, reg_dst_fmt_o;
  logic iord_o, mem_wr_o, pc_ld_o, pc_ld_cond_o, pc_src_jmp_o;
  logic [1:0] alu_b_sel_o;
  logic [3:0] alu_op_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  uctl_top u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .func_i(func_i),
    .ir_wr_o(ir_wr_o), .pc_inc_o(pc_inc_o), .alu_a_pc_o(alu_a_pc_o),
    .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o), .reg_wr_o(reg_wr_o),
    .reg_src_mem_o(reg_src_mem_o), .reg_dst_fmt_o(reg_dst_fmt_o),
    .iord_o(iord_o), .mem_wr_o(mem_wr_o), .pc_ld_o(pc_ld_o),
    .pc_ld_cond_o(pc_ld_cond_o), .pc_src_jmp_o(pc_src_jmp_o)
  );

  localparam logic [16:0] IRW = 17'h10000;
  localparam logic [16:0] PCI = 17'h08000;
  localparam logic [16:0] APC = 17'h04000;
  localparam logic [16:0] BSX = 17'h01000;
  localparam logic [16:0] BZX = 17'h02000;
  localparam logic [16:0] RW  = 17'h00080;
  localparam logic [16:0] SM  = 17'h00040;
  localparam logic [16:0] DF  = 17'h00020;
  localparam logic [16:0] IOD = 17'h00010;
  localparam logic [16:0] MW  = 17'h00008;
  localparam logic [16:0] PL  = 17'h00004;
  localparam logic [16:0] PLC = 17'h00002;
  localparam logic [16:0] PJ  = 17'h00001;
  localparam logic [16:0] FETCHV = IRW | PCI;
  localparam logic [16:0] DECV   = APC | BSX;

  function automatic logic [16:0] opf(input int x);
    return 17'(x) << 8;
  endfunction

  typedef struct packed {
    logic [15:0] instr;
    logic [1:0]  n;
    logic [16:0] c0;
    logic [16:0] c1;
    logic [16:0] c2;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TAB [NV] = '{
    '{16'h0000, 2'd1, 17'h0, 17'h0, 17'h0},
    '{16'h1231, 2'd2, opf(1), RW, 17'h0},
    '{16'h1002, 2'd2, opf(2), RW, 17'h0},
    '{16'h2400, 2'd2, opf(4), RW | DF, 17'h0},
    '{16'h3000, 2'd2, opf(5), RW | DF, 17'h0},
    '{16'h4005, 2'd3, BSX, IOD, RW | SM},
    '{16'h53FF, 2'd2, BSX, IOD | MW, 17'h0},
    '{16'h6123, 2'd1, PL | PJ, 17'h0, 17'h0},
    '{16'h7004, 2'd1, opf(1) | PLC, 17'h0, 17'h0},
    '{16'h8001, 2'd2, BSX, RW, 17'h0},
    '{16'h9001, 2'd2, BSX | opf(1), RW, 17'h0},
    '{16'hA00F, 2'd2, BZX | opf(2), RW, 17'h0},
    '{16'hB00F, 2'd2, BZX | opf(3), RW, 17'h0},
    '{16'hC00F, 2'd1, 17'h0, 17'h0, 17'h0},
    '{16'hF005, 2'd1, 17'h0, 17'h0, 17'h0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1:          return "R4";
      4'd2, 4'd3:    return "R5";
      4'd4:          return "R7";
      4'd5:          return "R6";
      4'd6, 4'd7:    return "R9";
      4'd8, 4'd9, 4'd10, 4'd11: return "R8";
      default:       return "R3";
    endcase
  endfunction

  function automatic logic [16:0] act();
    return {ir_wr_o, pc_inc_o, alu_a_pc_o, alu_b_sel_o, alu_op_o, reg_wr_o,
            reg_src_mem_o, reg_dst_fmt_o, iord_o, mem_wr_o, pc_ld_o,
            pc_ld_cond_o, pc_src_jmp_o};
  endfunction

  task automatic chk(input string req, input logic [16:0] exp);
    n_chk++;
    if (act() !== exp) begin
      n_fail++;
      $display("FAIL %s: controls actual %05h expected %05h", req, act(), exp);
    end
  endtask

  // Called at a negedge inside a fetch cycle; ends at the next fetch negedge.
  task automatic run_instr(input vec_t v);
    chk("R1", FETCHV);
    op_i   = v.instr[15:12];
    func_i = v.instr[3:0];
    @(negedge clk);
    chk("R2", DECV);
    @(negedge clk);
    chk(tag_of(v.instr[15:12]), v.c0);
    if (v.n > 2'd1) begin
      @(negedge clk);
      chk(tag_of(v.instr[15:12]), v.c1);
    end
    if (v.n > 2'd2) begin
      @(negedge clk);
      chk(tag_of(v.instr[15:12]), v.c2);
    end
    @(negedge clk);
    // R10: routine returned to fetch
    chk("R10", FETCHV);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL R10: watchdog expired actual %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", FETCHV);          // outputs during reset
    rst = 1'b0;
    chk("R1", FETCHV);          // first cycle after reset
    for (int i = 0; i < NV; i++) run_instr(TAB[i]);

    // R4: another function code passes through unchanged
    run_instr('{16'h100F, 2'd2, opf(15), RW, 17'h0});

    // R1: reset arriving in the middle of a load routine
    chk("R1", FETCHV);
    op_i = 4'd4;
    @(negedge clk);
    chk("R2", DECV);
    @(negedge clk);
    chk("R7", BSX);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", FETCHV);
    @(negedge clk);
    chk("R1", FETCHV);
    rst = 1'b0;
    chk("R1", FETCHV);
    run_instr(TAB[6]);          // store after reset recovery
    run_instr(TAB[0]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule